// File: doc/BRIEF.md
# Configuration Load Sequencer

This controller carries out one programming pass of a configurable logic array. After a start pulse it resets the array through a program line, when the load is a full one. It then clears and inspects the interrupt flags and runs a pre-flight check on the transfer command queue. Next it requests one word-stream transfer from an external engine, waits for that transfer to finish, and finally waits for the array to report that configuration is complete. It ends each pass with either a one-cycle success pulse or a one-cycle failure pulse plus a numeric reason code.

The flag register and the queue status belong to the surrounding configuration interface. The sequencer reads them as plain input vectors and clears flags through a write-one-to-clear strobe vector. Every wait has its own timeout, given in microseconds and turned into clock cycles from a clock-frequency parameter. A full load also gates the fabric interface: the enable output drops when a full load starts and rises again only when that load completes.

Top module: `cfg_load_seq`

## Requirements
- R1: Out of synchronous reset, prog_o is 1, fabric_en_o, busy_o, xfer_req_o, done_o, fail_o and all strobes are 0, and fail_code_o is 0.
- R2: A start_i accepted in idle gives a one-cycle loop_clr_o pulse in the next cycle, and busy_o stays 1 until the cycle that carries the result pulse.
- R3: A full load (partial_i=0) drives prog_o low, waits for init_i low, drives prog_o high, then waits for init_i high. A partial load (partial_i=1) leaves prog_o at 1 throughout.
- R4: A wait for init_i low or high that is still unmet after INIT_WAIT_US worth of cycles fails with code 1 or 2 respectively. Every failure returns prog_o to 1 and carries a nonzero code.
- R5: After the init handshake, the flag word is captured and flag_clr_o pulses all ones.
- R6: A captured flag inside 0x00740040 is fatal. If bit 18 (0x00040000) is among the fatal flags, fifo_flush_o pulses, then flag_clr_o pulses all ones again together with failure code 4. Otherwise the failure code is 3.
- R7: q_full_i high at the queue check fails with code 5.
- R8: With q_empty_i low at the queue check, a clear done flag (bit 13, 0x00002000) fails with code 6. A set done flag is cleared (flag_clr_o = 0x00002000) and the pass continues.
- R9: A nonzero done_cnt_i at the queue check pulses cnt_clr_o once.
- R10: xfer_req_o rises after the queue check and falls on xfer_ack_i. While the transfer runs, the done flag is cleared and the pass advances. Otherwise any flag in 0x00340840 fails with code 7, and no outcome within XFER_WAIT_US fails with code 8.
- R11: Flag bit 2 (0x00000004) within DONE_WAIT_US gives done_o, else code 9. A full start clears fabric_en_o, a full success sets it, and a partial load leaves it unchanged.
- R12: start_i while busy_o is 1 is ignored. done_o and fail_o are never high together, and the block is idle in the cycle of the result pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse for one load |
| partial_i | input | 1 | 1 = partial load, sampled with start_i |
| init_i | input | 1 | Array init status line |
| flags_i | input | 32 | Live interrupt flag word |
| q_full_i | input | 1 | Transfer command queue full |
| q_empty_i | input | 1 | Transfer command queue empty |
| done_cnt_i | input | 2 | Completed-transfer counter field |
| xfer_ack_i | input | 1 | Transfer engine accepted the request |
| prog_o | output | 1 | Program-reset line to the array |
| loop_clr_o | output | 1 | Pulse: clear loopback mode |
| flag_clr_o | output | 32 | Write-one-to-clear strobe for the flag word |
| fifo_flush_o | output | 1 | Pulse: flush the receive FIFO |
| cnt_clr_o | output | 1 | Pulse: clear the completed-transfer counter |
| xfer_req_o | output | 1 | Transfer request, held until acknowledged |
| fabric_en_o | output | 1 | Fabric interface enable |
| busy_o | output | 1 | A pass is running |
| done_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |
| fail_code_o | output | 4 | Reason of the last failure, 0 after success |

## Verification
The hardest paths to reach are the ones where a status flag has to appear, or stay away, after the blanket all-ones clear. Examples are the queue-not-empty case that continues because the done flag is set again, and the receive-overflow path that needs a second clear. The bench gets there with a reactive model of the surroundings. Injected flags can be one-shot or held, the init line follows the program line through a short delay or sticks at a level, and a transfer engine answers the request with done, error or silence. Each timeout is forced by simply withholding the awaited event, with short timeout parameters.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;

  localparam int unsigned FLAG_W = 32;

  localparam logic [FLAG_W-1:0] FATAL_MASK = 32'h0074_0040;
  localparam logic [FLAG_W-1:0] RXOV_BIT   = 32'h0004_0000;
  localparam logic [FLAG_W-1:0] XERR_MASK  = 32'h0034_0840;
  localparam logic [FLAG_W-1:0] XDONE_BIT  = 32'h0000_2000;
  localparam logic [FLAG_W-1:0] CDONE_BIT  = 32'h0000_0004;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PULSE, ST_WAIT_LOW, ST_RELEASE, ST_WAIT_HIGH, ST_SAMPLE,
    ST_CLASSIFY, ST_FLUSH_CLR, ST_QCHK, ST_XFER_WAIT, ST_XFER_END, ST_CFG_WAIT
  } seq_state_e;

  typedef enum logic [3:0] {
    FC_NONE      = 4'd0,
    FC_INIT_LOW  = 4'd1,
    FC_INIT_HIGH = 4'd2,
    FC_FATAL     = 4'd3,
    FC_RXOV      = 4'd4,
    FC_BUSY      = 4'd5,
    FC_QUEUE     = 4'd6,
    FC_XFER_ERR  = 4'd7,
    FC_XFER_TMO  = 4'd8,
    FC_CFG_TMO   = 4'd9
  } fail_code_e;

  function automatic int unsigned us_to_cycles(int unsigned hz, int unsigned us);
    longint unsigned prod;
    prod = (longint'(hz) * longint'(us)) / 64'd1000000;
    return (prod == 0) ? 32'd1 : 32'(prod);
  endfunction

endpackage

// File: rtl/cfg_seq_timer.sv
module cfg_seq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);

  logic [W-1:0] cnt;

  assign expired = run && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < limit)); // R4

endmodule

// File: rtl/cfg_flag_eval.sv
module cfg_flag_eval
  import cfg_load_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              fatal_o,
  output logic              rxov_o,
  output logic              xerr_o,
  output logic              xdone_o,
  output logic              cdone_o
);

  logic [FLAG_W-1:0] snap;

  always_ff @(posedge clk) begin
    if (rst) snap <= '0;
    else if (capture) snap <= flags_i;
  end

  assign fatal_o = |(snap & FATAL_MASK);
  assign rxov_o  = |(snap & RXOV_BIT);
  assign xerr_o  = |(flags_i & XERR_MASK);
  assign xdone_o = |(flags_i & XDONE_BIT);
  assign cdone_o = |(flags_i & CDONE_BIT);

endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
  import cfg_load_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 250_000_000,
  parameter int unsigned INIT_WAIT_US = 10_000,
  parameter int unsigned XFER_WAIT_US = 4_000_000,
  parameter int unsigned DONE_WAIT_US = 10_000,
  parameter int unsigned CNT_W        = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              partial_i,
  input  logic              init_i,
  input  logic [31:0]       flags_i,
  input  logic              q_full_i,
  input  logic              q_empty_i,
  input  logic [CNT_W-1:0]  done_cnt_i,
  input  logic              xfer_ack_i,
  output logic              prog_o,
  output logic              loop_clr_o,
  output logic [31:0]       flag_clr_o,
  output logic              fifo_flush_o,
  output logic              cnt_clr_o,
  output logic              xfer_req_o,
  output logic              fabric_en_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [3:0]        fail_code_o
);

  localparam int unsigned INIT_CYC = us_to_cycles(CLK_HZ, INIT_WAIT_US);
  localparam int unsigned XFER_CYC = us_to_cycles(CLK_HZ, XFER_WAIT_US);
  localparam int unsigned DONE_CYC = us_to_cycles(CLK_HZ, DONE_WAIT_US);
  localparam int unsigned MAX_A    = (INIT_CYC > DONE_CYC) ? INIT_CYC : DONE_CYC;
  localparam int unsigned MAX_CYC  = (MAX_A > XFER_CYC) ? MAX_A : XFER_CYC;
  localparam int unsigned TW       = $clog2(MAX_CYC + 1);

  seq_state_e state_q, state_d;
  logic       partial_q;

  logic          tmr_run, tmr_exp;
  logic [TW-1:0] tmr_limit;
  logic          capture, fatal, rxov, xerr, xdone, cdone;

  logic              prog_d, loop_clr_d, flush_d, cnt_clr_d;
  logic [FLAG_W-1:0] flag_clr_d;
  logic              req_set, req_clr, fab_set, fab_clr;
  logic              done_req, fail_req, start_acc;
  fail_code_e        code_d;

  assign tmr_run = (state_q == ST_WAIT_LOW) || (state_q == ST_WAIT_HIGH) ||
                   (state_q == ST_XFER_WAIT) || (state_q == ST_CFG_WAIT);

  always_comb begin
    case (state_q)
      ST_XFER_WAIT: tmr_limit = TW'(XFER_CYC);
      ST_CFG_WAIT:  tmr_limit = TW'(DONE_CYC);
      default:      tmr_limit = TW'(INIT_CYC);
    endcase
  end

  cfg_seq_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .run(tmr_run), .limit(tmr_limit), .expired(tmr_exp)
  );

  cfg_flag_eval u_flags (
    .clk(clk), .rst(rst), .capture(capture), .flags_i(flags_i),
    .fatal_o(fatal), .rxov_o(rxov), .xerr_o(xerr), .xdone_o(xdone), .cdone_o(cdone)
  );

  always_comb begin
    state_d    = state_q;
    prog_d     = prog_o;
    loop_clr_d = 1'b0;
    flag_clr_d = '0;
    flush_d    = 1'b0;
    cnt_clr_d  = 1'b0;
    req_set    = 1'b0;
    req_clr    = 1'b0;
    fab_set    = 1'b0;
    fab_clr    = 1'b0;
    capture    = 1'b0;
    done_req   = 1'b0;
    fail_req   = 1'b0;
    start_acc  = 1'b0;
    code_d     = FC_NONE;
    case (state_q)
      ST_IDLE: if (start_i) begin
        start_acc  = 1'b1;
        loop_clr_d = 1'b1;
        if (partial_i) state_d = ST_SAMPLE;
        else begin
          fab_clr = 1'b1;
          state_d = ST_PULSE;
        end
      end
      ST_PULSE: begin
        prog_d  = 1'b0;
        state_d = ST_WAIT_LOW;
      end
      ST_WAIT_LOW: begin
        if (!init_i) state_d = ST_RELEASE;
        else if (tmr_exp) begin fail_req = 1'b1; code_d = FC_INIT_LOW; end
      end
      ST_RELEASE: begin
        prog_d  = 1'b1;
        state_d = ST_WAIT_HIGH;
      end
      ST_WAIT_HIGH: begin
        if (init_i) state_d = ST_SAMPLE;
        else if (tmr_exp) begin fail_req = 1'b1; code_d = FC_INIT_HIGH; end
      end
      ST_SAMPLE: begin
        capture    = 1'b1;
        flag_clr_d = '1;
        state_d    = ST_CLASSIFY;
      end
      ST_CLASSIFY: begin
        if (fatal && rxov) begin
          flush_d = 1'b1;
          state_d = ST_FLUSH_CLR;
        end else if (fatal) begin
          fail_req = 1'b1; code_d = FC_FATAL;
        end else state_d = ST_QCHK;
      end
      ST_FLUSH_CLR: begin
        flag_clr_d = '1;
        fail_req   = 1'b1;
        code_d     = FC_RXOV;
      end
      ST_QCHK: begin
        if (q_full_i) begin
          fail_req = 1'b1; code_d = FC_BUSY;
        end else if (!q_empty_i && !xdone) begin
          fail_req = 1'b1; code_d = FC_QUEUE;
        end else begin
          if (!q_empty_i) flag_clr_d = XDONE_BIT;
          cnt_clr_d = |done_cnt_i;
          req_set   = 1'b1;
          state_d   = ST_XFER_WAIT;
        end
      end
      ST_XFER_WAIT: begin
        if (xfer_ack_i) req_clr = 1'b1;
        if (xdone) begin
          flag_clr_d = XDONE_BIT;
          req_clr    = 1'b1;
          state_d    = ST_XFER_END;
        end else if (xerr) begin
          fail_req = 1'b1; code_d = FC_XFER_ERR;
        end else if (tmr_exp) begin
          fail_req = 1'b1; code_d = FC_XFER_TMO;
        end
      end
      ST_XFER_END: state_d = ST_CFG_WAIT;
      ST_CFG_WAIT: begin
        if (cdone) begin
          done_req = 1'b1;
          fab_set  = !partial_q;
          state_d  = ST_IDLE;
        end else if (tmr_exp) begin
          fail_req = 1'b1; code_d = FC_CFG_TMO;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (fail_req) begin
      state_d = ST_IDLE;
      prog_d  = 1'b1;
      req_clr = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      partial_q    <= 1'b0;
      prog_o       <= 1'b1;
      loop_clr_o   <= 1'b0;
      flag_clr_o   <= '0;
      fifo_flush_o <= 1'b0;
      cnt_clr_o    <= 1'b0;
      xfer_req_o   <= 1'b0;
      fabric_en_o  <= 1'b0;
      busy_o       <= 1'b0;
      done_o       <= 1'b0;
      fail_o       <= 1'b0;
      fail_code_o  <= 4'd0;
    end else begin
      state_q      <= state_d;
      prog_o       <= prog_d;
      loop_clr_o   <= loop_clr_d;
      flag_clr_o   <= flag_clr_d;
      fifo_flush_o <= flush_d;
      cnt_clr_o    <= cnt_clr_d;
      xfer_req_o   <= req_set | (xfer_req_o & ~req_clr);
      busy_o       <= (state_d != ST_IDLE);
      done_o       <= done_req;
      fail_o       <= fail_req;
      if (start_acc) partial_q <= partial_i;
      if (fab_set) fabric_en_o <= 1'b1;
      else if (fab_clr) fabric_en_o <= 1'b0;
      if (fail_req) fail_code_o <= code_d;
      else if (start_acc) fail_code_o <= 4'd0;
    end
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    !(done_o && fail_o)); // R12
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> !loop_clr_o); // R12
  AST_PARTIAL_PROG: assert property (@(posedge clk) disable iff (rst)
    (busy_o && partial_q) |-> prog_o); // R3
  AST_FAIL_CODED: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> (fail_code_o != 4'd0 && prog_o)); // R4
  AST_FLUSH_THEN_FAIL: assert property (@(posedge clk) disable iff (rst)
    fifo_flush_o |=> (fail_o && flag_clr_o == '1 && fail_code_o == 4'd4)); // R6
  AST_REQ_IN_PASS: assert property (@(posedge clk) disable iff (rst)
    xfer_req_o |-> busy_o); // R10
  AST_FABRIC_HOLD: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> ($stable(fabric_en_o) || done_o)); // R11

endmodule

// File: tb/tb_cfg_load_seq.sv
module tb_cfg_load_seq;

  localparam int LIM_INIT = 20;
  localparam int LIM_XFER = 60;
  localparam int LIM_DONE = 20;
  localparam int XLAT = 5;
  localparam int CLAT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, partial = 1'b0, init_line = 1'b1;
  logic [31:0] env_flags = '0;
  logic q_full = 1'b0, q_empty = 1'b1, xfer_ack = 1'b0;
  logic [1:0] done_cnt = 2'd0;

  logic prog, loop_clr, flush, cnt_clr, xreq, fab, busy, done, fail;
  logic [31:0] flag_clr;
  logic [3:0] code;

  always #2 clk = ~clk;

  cfg_load_seq #(.CLK_HZ(1_000_000), .INIT_WAIT_US(LIM_INIT),
                 .XFER_WAIT_US(LIM_XFER), .DONE_WAIT_US(LIM_DONE), .CNT_W(2)) dut (
    .clk(clk), .rst(rst), .start_i(start), .partial_i(partial), .init_i(init_line),
    .flags_i(env_flags), .q_full_i(q_full), .q_empty_i(q_empty), .done_cnt_i(done_cnt),
    .xfer_ack_i(xfer_ack), .prog_o(prog), .loop_clr_o(loop_clr), .flag_clr_o(flag_clr),
    .fifo_flush_o(flush), .cnt_clr_o(cnt_clr), .xfer_req_o(xreq), .fabric_en_o(fab),
    .busy_o(busy), .done_o(done), .fail_o(fail), .fail_code_o(code));

  int n_chk = 0, n_bad = 0;

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- environment ----------------
  int init_mode = 0;    // 0 follow prog, 1 stuck high, 2 stuck low
  int xmode = 0;        // 0 done, 1 error, 2 silent
  int cmode = 0;        // 0 config done, 1 never
  logic [31:0] hold_mask = '0, inj_pre = '0;
  logic [7:0] prog_hist = '1;
  int x_t = -1, c_t = -1;
  int loop_seen = 0, cnt_seen = 0, allclr_seen = 0;

  // ---------------- reference model state ----------------
  int m_stage = 0, m_el = 0;
  bit m_part = 0;
  logic [31:0] m_snap = '0;
  logic e_prog = 1, e_loop = 0, e_flush = 0, e_cnt = 0, e_req = 0;
  logic e_fab = 0, e_busy = 0, e_done = 0, e_fail = 0;
  logic [31:0] e_clr = '0;
  logic [3:0] e_code = 0;

  always @(negedge clk) begin
    logic [31:0] inj;
    if (!rst) begin
      cmp("R3 prog_o", prog, e_prog);
      cmp("R2 loop_clr_o", loop_clr, e_loop);
      cmp("R5 flag_clr_o", flag_clr, e_clr);
      cmp("R6 fifo_flush_o", flush, e_flush);
      cmp("R9 cnt_clr_o", cnt_clr, e_cnt);
      cmp("R10 xfer_req_o", xreq, e_req);
      cmp("R11 fabric_en_o", fab, e_fab);
      cmp("R12 busy_o", busy, e_busy);
      cmp("R11 done_o", done, e_done);
      cmp("R4 fail_o", fail, e_fail);
      cmp("R4 fail_code_o", code, e_code);
    end
    if (loop_clr) loop_seen++;
    if (cnt_clr) cnt_seen++;
    if (flag_clr == 32'hFFFF_FFFF) allclr_seen++;
    prog_hist = {prog_hist[6:0], prog};
    init_line = (init_mode == 1) ? 1'b1 : (init_mode == 2) ? 1'b0 : prog_hist[2];
    inj = inj_pre;
    inj_pre = '0;
    if (!busy) begin x_t = -1; c_t = -1; end
    xfer_ack = 1'b0;
    if (xreq && x_t < 0) begin
      xfer_ack = 1'b1; x_t = 0;
    end else if (x_t >= 0) begin
      x_t++;
      if (x_t == XLAT) begin
        if (xmode == 0) begin inj |= 32'h0000_2000; c_t = 0; end
        else if (xmode == 1) inj |= 32'h0000_0800;
      end
    end
    if (c_t >= 0) begin
      c_t++;
      if (c_t == CLAT && cmode == 0) inj |= 32'h0000_0004;
    end
    env_flags = (env_flags & ~flag_clr) | inj | hold_mask;
  end

  // ---------------- cycle reference model ----------------
  always @(posedge clk) begin
    int prev;
    bit tmo;
    if (rst) begin
      m_stage = 0; m_el = 0; m_part = 0; m_snap = '0;
      e_prog = 1; e_loop = 0; e_clr = '0; e_flush = 0; e_cnt = 0; e_req = 0;
      e_fab = 0; e_busy = 0; e_done = 0; e_fail = 0; e_code = 0;
    end else begin
      prev = m_stage;
      e_loop = 0; e_clr = '0; e_flush = 0; e_cnt = 0; e_done = 0; e_fail = 0;
      tmo = 0;
      case (m_stage)
        0: if (start) begin
          e_loop = 1; e_code = 0; m_part = partial;
          if (partial) m_stage = 5; else begin e_fab = 0; m_stage = 1; end
        end
        1: begin e_prog = 0; m_stage = 2; end
        2: if (!init_line) m_stage = 3;
           else if (m_el == LIM_INIT - 1) begin tmo = 1; e_code = 1; end
        3: begin e_prog = 1; m_stage = 4; end
        4: if (init_line) m_stage = 5;
           else if (m_el == LIM_INIT - 1) begin tmo = 1; e_code = 2; end
        5: begin m_snap = env_flags; e_clr = '1; m_stage = 6; end
        6: if ((m_snap & 32'h0074_0040) != 0) begin
             if (m_snap[18]) begin e_flush = 1; m_stage = 7; end
             else begin tmo = 1; e_code = 3; end
           end else m_stage = 8;
        7: begin e_clr = '1; tmo = 1; e_code = 4; end
        8: if (q_full) begin tmo = 1; e_code = 5; end
           else if (!q_empty && !env_flags[13]) begin tmo = 1; e_code = 6; end
           else begin
             if (!q_empty) e_clr = 32'h0000_2000;
             e_cnt = (done_cnt != 0);
             e_req = 1; m_stage = 9;
           end
        9: begin
          if (xfer_ack) e_req = 0;
          if (env_flags[13]) begin e_clr = 32'h0000_2000; e_req = 0; m_stage = 10; end
          else if ((env_flags & 32'h0034_0840) != 0) begin tmo = 1; e_code = 7; end
          else if (m_el == LIM_XFER - 1) begin tmo = 1; e_code = 8; end
        end
        10: m_stage = 11;
        11: if (env_flags[2]) begin
              e_done = 1; m_stage = 0;
              if (!m_part) e_fab = 1;
            end else if (m_el == LIM_DONE - 1) begin tmo = 1; e_code = 9; end
        default: m_stage = 0;
      endcase
      if (tmo) begin e_fail = 1; m_stage = 0; e_prog = 1; e_req = 0; end
      if (m_stage == prev && (m_stage == 2 || m_stage == 4 || m_stage == 9 || m_stage == 11))
        m_el++;
      else m_el = 0;
      e_busy = (m_stage != 0);
    end
  end

  // ---------------- stimulus ----------------
  task automatic run_load(bit p, string tag, int exp_code, bit exp_done, logic exp_fab);
    int guard;
    @(negedge clk); start = 1'b1; partial = p;
    @(negedge clk); start = 1'b0;
    guard = 0;
    while (!(done || fail) && guard < 400) begin @(negedge clk); guard++; end
    cmp({tag, " fail_code"}, code, exp_code);
    cmp({tag, " done"}, done, exp_done);
    cmp({tag, " fabric_en"}, fab, exp_fab);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    cmp("R1 prog_o", prog, 1); cmp("R1 busy_o", busy, 0); cmp("R1 fabric_en_o", fab, 0);
    cmp("R1 xfer_req_o", xreq, 0); cmp("R1 fail_code_o", code, 0); cmp("R1 flag_clr_o", flag_clr, 0);

    // R3 R11 R12: full success, a second start mid-pass ignored
    loop_seen = 0; allclr_seen = 0;
    @(negedge clk); start = 1'b1; partial = 1'b0;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1; partial = 1'b1;
    @(negedge clk); start = 1'b0;
    begin
      int g = 0;
      while (!(done || fail) && g < 400) begin @(negedge clk); g++; end
    end
    cmp("R11 full done", done, 1); cmp("R11 full fabric", fab, 1);
    cmp("R2 R12 one loop_clr per pass", loop_seen, 1);
    cmp("R5 all-ones clear seen", allclr_seen, 1);
    repeat (3) @(negedge clk);

    run_load(1, "R3 partial", 0, 1, 1);
    init_mode = 1; run_load(0, "R4 init low timeout", 1, 0, 0);
    init_mode = 2; run_load(0, "R4 init high timeout", 2, 0, 0);
    init_mode = 0;
    inj_pre = 32'h0000_0040; @(negedge clk);
    run_load(1, "R6 fatal", 3, 0, 0);
    allclr_seen = 0;
    inj_pre = 32'h0004_0000; @(negedge clk);
    run_load(1, "R6 rx overflow", 4, 0, 0);
    cmp("R6 second all-ones clear", allclr_seen, 2);
    q_full = 1'b1; run_load(1, "R7 queue full", 5, 0, 0); q_full = 1'b0;
    q_empty = 1'b0; run_load(1, "R8 queue pending", 6, 0, 0);
    hold_mask = 32'h0000_2000; run_load(1, "R8 pending with done", 0, 1, 0);
    hold_mask = '0; q_empty = 1'b1;
    repeat (2) @(negedge clk);
    cnt_seen = 0; done_cnt = 2'd2;
    run_load(0, "R9 counter clear", 0, 1, 1);
    cmp("R9 cnt_clr pulses", cnt_seen, 1);
    done_cnt = 2'd0;
    xmode = 1; run_load(1, "R10 transfer error", 7, 0, 1);
    xmode = 2; run_load(1, "R10 transfer timeout", 8, 0, 1);
    xmode = 0; cmode = 1; run_load(0, "R11 config timeout", 9, 0, 0);
    cmode = 0; run_load(0, "R11 full recovery", 0, 1, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule